// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog counter clocked by the system clock. Unless software keeps restarting it, it raises a one-cycle reset request once a programmable number of cycles has passed. Software controls it through one 8-bit register, with a write strobe, write data and a read port. A write with the top bit clear sets the timeout selector. A write with the top bit set is treated as a key. One key restarts and enables the counter. A pair of keys written close together switches the watchdog off. A further key locks out the switch-off pair until the next reset.

The timeout is a power of four. With the 3-bit selector value n, the count limit is 4^(BASE_POW+n) cycles. With the default BASE_POW of 3 this spans 64 to 2^20 cycles, held in a 21-bit counter. After a reset, and after each reset request it issues, the block is enabled and counting, unlocked, and set to the longest timeout.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the read port returns 8'h07, the reset request is low, and the counter is running: with no writes the request rises exactly 4^(BASE_POW+7) cycles after reset release.
- R2: A write of 8'hA5 enables the watchdog and restarts the count, so the request rises exactly 4^(BASE_POW+n) clock edges after the last such write.
- R3: With selector value n, the timeout is 4^(BASE_POW+n) clock cycles.
- R4: A write of 8'hDE followed by a write of 8'hAD at most 4 clock edges later (gap counted in edges from write to write) disables the watchdog, and no request follows.
- R5: If the gap between 8'hDE and 8'hAD is 5 edges or more, the pair has no effect and the timeout runs as before.
- R6: Any write other than 8'hAD that lands between 8'hDE and 8'hAD cancels the pending disable.
- R7: A write of 8'hFF sets a lock under which the disable pair is ignored until the next reset. The 8'hFF write does not restart or enable the counter. An external reset clears the lock.
- R8: A write with bit 7 equal to 0 loads bits [2:0] into the selector. The read port returns the selector in bits [2:0] and zeros in bits [7:3].
- R9: Writes with bit 7 set (8'hA5, 8'hDE, 8'hAD, 8'hFF and any other such byte) never change the selector.
- R10: The reset request lasts one cycle. In that cycle the read port already shows 8'h07. Afterwards the block is enabled, counting from zero and unlocked.
- R11: While disabled, the counter stays at zero. A later 8'hA5 write restarts it from zero with the full timeout.
- R12: If the selector is lowered below the count already reached, the request rises on the next clock edge. The limit is a threshold, not an exact match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_data_i | input | DATA_W | Write data: a key byte, or a selector update when the top bit is clear |
| rd_data_o | output | DATA_W | Read data: the timeout selector, zero-extended |
| rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with BASE_POW set to 1 and keeps the other parameters at their defaults. The eight timeouts then run from 4 to 65536 cycles. This short base lets a run watch the power-on timeout expire in full and sweep a range of selector values edge-exactly. It also lets the bench place a disable pair or a lowered selector at a known count. The disable window is tested at both of its edges, a gap of four and a gap of five. These tests use a 64-cycle timeout, which leaves room for several writes before expiry.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_KICK  = 3'd1,
      CMD_ARM1  = 3'd2,
      CMD_ARM2  = 3'd3,
      CMD_LOCK  = 3'd4,
      CMD_SEL   = 3'd5,
      CMD_OTHER = 3'd6
   } wdk_cmd_e;

   // exponent of two for selector value sel (timeout = 4^(base_pow+sel))
   function automatic int unsigned term_exp(int unsigned base_pow, int unsigned sel);
      return 2 * (base_pow + sel);
   endfunction

   // counter width able to hold the largest terminal value, plus one spare bit
   function automatic int unsigned cnt_bits(int unsigned base_pow, int unsigned sel_w);
      return 2 * (base_pow + (1 << sel_w) - 1) + 1;
   endfunction

endpackage

// File: rtl/wdk_keydec.sv
module wdk_keydec
   import wdk_pkg::*;
#(
   parameter int unsigned       DATA_W   = 8,
   parameter logic [DATA_W-1:0] KICK_KEY = 8'hA5,
   parameter logic [DATA_W-1:0] ARM1_KEY = 8'hDE,
   parameter logic [DATA_W-1:0] ARM2_KEY = 8'hAD,
   parameter logic [DATA_W-1:0] LOCK_KEY = 8'hFF
) (
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output wdk_cmd_e          cmd_o
);

   localparam int unsigned TOP = DATA_W - 1;

   // every key must sit in the upper half so it never looks like a selector update
   if (!KICK_KEY[TOP] || !ARM1_KEY[TOP] || !ARM2_KEY[TOP] || !LOCK_KEY[TOP]) begin : g_bad_key
      $error("wdk_keydec: key values must have the top data bit set");
   end
   if (KICK_KEY == ARM1_KEY || KICK_KEY == ARM2_KEY || KICK_KEY == LOCK_KEY ||
       ARM1_KEY == ARM2_KEY || ARM1_KEY == LOCK_KEY || ARM2_KEY == LOCK_KEY) begin : g_dup_key
      $error("wdk_keydec: key values must be distinct");
   end

   always_comb begin
      cmd_o = CMD_NONE;
      if (wr_en_i) begin
         if (!wr_data_i[TOP]) begin
            cmd_o = CMD_SEL;
         end else if (wr_data_i == KICK_KEY) begin
            cmd_o = CMD_KICK;
         end else if (wr_data_i == ARM1_KEY) begin
            cmd_o = CMD_ARM1;
         end else if (wr_data_i == ARM2_KEY) begin
            cmd_o = CMD_ARM2;
         end else if (wr_data_i == LOCK_KEY) begin
            cmd_o = CMD_LOCK;
         end else begin
            cmd_o = CMD_OTHER;
         end
      end
   end

endmodule

// File: rtl/wdk_arm.sv
module wdk_arm
   import wdk_pkg::*;
#(
   parameter int unsigned WIN = 4
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     fire_i,
   input  wdk_cmd_e cmd_i,
   output logic     en_o
);

   localparam int unsigned AGE_W = $clog2(WIN + 1);
   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WIN);
   localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

   if (WIN < 1) begin : g_bad_win
      $error("wdk_arm: WIN must be at least 1");
   end

   logic             en_q,   en_d;
   logic             lock_q, lock_d;
   logic             pend_q, pend_d;
   logic [AGE_W-1:0] age_q,  age_d;

   always_comb begin
      en_d   = en_q;
      lock_d = lock_q;
      pend_d = pend_q;
      age_d  = age_q;
      if (fire_i) begin
         // timeout: back to power-on state, writes in this cycle are dropped
         en_d   = 1'b1;
         lock_d = 1'b0;
         pend_d = 1'b0;
         age_d  = '0;
      end else begin
         unique case (cmd_i)
            CMD_NONE: begin
               if (pend_q) begin
                  if (age_q == AGE_MAX) begin
                     pend_d = 1'b0;
                     age_d  = '0;
                  end else begin
                     age_d = age_q + AGE_ONE;
                  end
               end
            end
            CMD_KICK: begin
               en_d   = 1'b1;
               pend_d = 1'b0;
            end
            CMD_ARM1: begin
               pend_d = !lock_q;
               age_d  = AGE_ONE;
            end
            CMD_ARM2: begin
               if (pend_q && !lock_q) begin
                  en_d = 1'b0;
               end
               pend_d = 1'b0;
            end
            CMD_LOCK: begin
               lock_d = 1'b1;
               pend_d = 1'b0;
            end
            default: begin
               pend_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= 1'b1;
         lock_q <= 1'b0;
         pend_q <= 1'b0;
         age_q  <= '0;
      end else begin
         en_q   <= en_d;
         lock_q <= lock_d;
         pend_q <= pend_d;
         age_q  <= age_d;
      end
   end

   assign en_o = en_q;

   // R5: a pending first key never outlives its window
   p_window_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q |-> (age_q >= AGE_ONE) && (age_q <= AGE_MAX));

   // R7: while locked, nothing can switch the watchdog off
   p_lock_holds_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && en_q) |=> en_q);

   // R4: disabling happens only on a second key that meets a live first key
   p_off_needs_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q && cmd_i != CMD_ARM2) |=> en_q);

   // R10: after a timeout the lock is gone and the watchdog is running
   p_fire_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i |=> (en_q && !lock_q && !pend_q));

endmodule

// File: rtl/wdk_tick.sv
module wdk_tick
   import wdk_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BASE_POW = 3,
   parameter int unsigned CNT_W    = cnt_bits(BASE_POW, SEL_W),
   parameter bit          CMP_GE   = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             clear_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             fire_o,
   output logic             req_o
);

   localparam int unsigned NSEL = 1 << SEL_W;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] term_tab [NSEL];
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] term;
   logic             hit;
   logic             req_q;

   // terminal count per selector value: 4^(BASE_POW+g) - 1
   for (genvar g = 0; g < NSEL; g++) begin : g_term
      localparam int unsigned EXP = term_exp(BASE_POW, g);
      if (EXP >= CNT_W) begin : g_too_narrow
         $error("wdk_tick: CNT_W too small for the selected timeout range");
      end
      assign term_tab[g] = (CNT_ONE << EXP) - CNT_ONE;
   end

   assign term = term_tab[sel_i];

   // threshold compare survives a selector lowered below the count;
   // equality is cheaper but would then wrap around once
   if (CMP_GE) begin : g_cmp_ge
      assign hit = (cnt_q >= term);
   end else begin : g_cmp_eq
      assign hit = (cnt_q == term);
   end

   assign fire_o = en_i & hit;

   always_comb begin
      if (fire_o || clear_i || !en_i) begin
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q + CNT_ONE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         req_q <= fire_o;
      end
   end

   assign req_o = req_q;

   // R10: the request is a single-cycle pulse
   p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q |=> !req_q);

   // R11: a disabled watchdog leaves the count at zero
   p_off_holds_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (cnt_q == '0));

   // R3: a request only follows a cycle in which the watchdog was enabled
   p_req_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q |-> $past(en_i));

   // R2: a restart write leaves the count at zero unless the timeout fired
   p_kick_restarts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import wdk_pkg::*;
#(
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       SEL_W    = 3,
   parameter int unsigned       BASE_POW = 3,
   parameter int unsigned       CNT_W    = cnt_bits(BASE_POW, SEL_W),
   parameter int unsigned       WIN      = 4,
   parameter bit                CMP_GE   = 1'b1,
   parameter logic [DATA_W-1:0] KICK_KEY = 8'hA5,
   parameter logic [DATA_W-1:0] ARM1_KEY = 8'hDE,
   parameter logic [DATA_W-1:0] ARM2_KEY = 8'hAD,
   parameter logic [DATA_W-1:0] LOCK_KEY = 8'hFF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rst_req_o
);

   localparam int unsigned PAD_W = DATA_W - SEL_W;

   if (DATA_W <= SEL_W) begin : g_bad_width
      $error("keyed_wdog: DATA_W must exceed SEL_W to leave room for the key flag");
   end
   if (CNT_W < cnt_bits(BASE_POW, SEL_W)) begin : g_bad_cnt
      $error("keyed_wdog: CNT_W cannot hold the largest timeout");
   end

   wdk_cmd_e         cmd;
   logic             en;
   logic             fire;
   logic [SEL_W-1:0] sel_q;

   wdk_keydec #(
      .DATA_W   (DATA_W),
      .KICK_KEY (KICK_KEY),
      .ARM1_KEY (ARM1_KEY),
      .ARM2_KEY (ARM2_KEY),
      .LOCK_KEY (LOCK_KEY)
   ) u_keydec (
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .cmd_o     (cmd)
   );

   wdk_arm #(
      .WIN (WIN)
   ) u_arm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (fire),
      .cmd_i  (cmd),
      .en_o   (en)
   );

   wdk_tick #(
      .SEL_W    (SEL_W),
      .BASE_POW (BASE_POW),
      .CNT_W    (CNT_W),
      .CMP_GE   (CMP_GE)
   ) u_tick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en),
      .clear_i (cmd == CMD_KICK),
      .sel_i   (sel_q),
      .fire_o  (fire),
      .req_o   (rst_req_o)
   );

   // timeout selector: all ones is the longest interval
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= '1;
      end else if (fire) begin
         sel_q <= '1;
      end else if (cmd == CMD_SEL) begin
         sel_q <= wr_data_i[SEL_W-1:0];
      end
   end

   assign rd_data_o = {{PAD_W{1'b0}}, sel_q};

   // R9: key writes leave the selector alone
   p_keys_keep_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[DATA_W-1] && !fire) |=> $stable(sel_q));

   // R8: a selector write lands in the read port one cycle later
   p_sel_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_data_i[DATA_W-1] && !fire) |=> (rd_data_o == DATA_W'($past(wr_data_i[SEL_W-1:0]))));

   // R10: the request cycle already shows the power-on selector
   p_fire_restores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> (sel_q == '1));

endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       rst_req;

   int checks = 0;
   int errors = 0;
   int edges  = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) edges <= edges + 1;

   keyed_wdog #(.BASE_POW(1)) u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .rd_data_o (rd_data),
      .rst_req_o (rst_req)
   );

   typedef struct packed {
      logic [7:0]  wbyte;
      logic [2:0]  sel;
      logic [31:0] lim;
   } vec_t;

   // selector writes (bit 7 clear) and the timeout each must give with BASE_POW=1
   localparam vec_t VECS [5] = '{
      '{8'h00, 3'd0, 32'd4},
      '{8'h01, 3'd1, 32'd16},
      '{8'h7A, 3'd2, 32'd64},
      '{8'h03, 3'd3, 32'd256},
      '{8'h4C, 3'd4, 32'd1024}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] b);
      wr_en   = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 8'h00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
   endtask

   // request must stay low until t0+lim-1 edges, rise after edge t0+lim, then drop
   task automatic wait_fire(input int t0, input int lim, input string tag);
      int bad = 0;
      while (edges < t0 + lim - 1) begin
         @(negedge clk);
         if (rst_req) bad++;
      end
      check(bad == 0, {tag, " early request"}, bad, 0);
      @(negedge clk);
      check(rst_req == 1'b1, {tag, " request at timeout"}, int'(rst_req), 1);
      check(rd_data == 8'h07, "R10 selector restored in request cycle", int'(rd_data), 7);
      @(negedge clk);
      check(rst_req == 1'b0, "R10 single-cycle request", int'(rst_req), 0);
   endtask

   task automatic watch_quiet(input int n, input string tag);
      int bad = 0;
      repeat (n) begin
         @(negedge clk);
         if (rst_req) bad++;
      end
      check(bad == 0, {tag, " no request while disabled"}, bad, 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int t0;
      // R1: reset state and power-on timeout 4^(1+7)
      idle(2);
      rst_n = 1'b1;
      t0 = edges;
      check(rd_data == 8'h07, "R1 reset selector", int'(rd_data), 7);
      check(rst_req == 1'b0, "R1 reset request low", int'(rst_req), 0);
      wait_fire(t0, 65536, "R1");

      // R3/R8: table of selector writes and timeouts
      foreach (VECS[i]) begin
         wr(VECS[i].wbyte);
         check(rd_data == {5'b0, VECS[i].sel}, "R8 selector readback",
               int'(rd_data), int'(VECS[i].sel));
         wr(8'hA5);
         t0 = edges;
         wait_fire(t0, int'(VECS[i].lim), "R3");
      end

      // R2: a second restart write moves the deadline
      wr(8'h02);
      wr(8'hA5);
      idle(40);
      wr(8'hA5);
      t0 = edges;
      wait_fire(t0, 64, "R2");

      // R4: disable pair with a gap of exactly 4 edges
      wr(8'h02);
      wr(8'hA5);
      wr(8'hDE);
      idle(3);
      wr(8'hAD);
      watch_quiet(200, "R4");

      // R11: restart from disabled counts the full timeout from zero
      wr(8'hA5);
      t0 = edges;
      wait_fire(t0, 64, "R11");

      // R5: gap of 5 edges is too late
      wr(8'h02);
      wr(8'hA5);
      t0 = edges;
      wr(8'hDE);
      idle(4);
      wr(8'hAD);
      wait_fire(t0, 64, "R5");

      // R6: an intervening write cancels the pending disable
      wr(8'h02);
      wr(8'hA5);
      wr(8'hDE);
      wr(8'hA5);
      t0 = edges;
      wr(8'hAD);
      wait_fire(t0, 64, "R6");

      // R7: lock neither restarts the count nor permits the disable pair
      wr(8'h02);
      wr(8'hA5);
      t0 = edges;
      wr(8'hFF);
      wr(8'hDE);
      wr(8'hAD);
      wait_fire(t0, 64, "R7");

      // R10: the timeout cleared the lock, so the pair works again
      wr(8'h02);
      wr(8'hA5);
      wr(8'hDE);
      wr(8'hAD);
      watch_quiet(150, "R10");

      // R9: key bytes never touch the selector
      wr(8'h03);
      check(rd_data == 8'h03, "R8 selector load", int'(rd_data), 3);
      wr(8'hA5);
      wr(8'hDE);
      wr(8'hAD);
      wr(8'hFF);
      wr(8'hC3);
      check(rd_data == 8'h03, "R9 keys keep selector", int'(rd_data), 3);

      // R7: external reset clears the lock set above
      do_reset();
      check(rd_data == 8'h07, "R1 selector after second reset", int'(rd_data), 7);
      wr(8'h02);
      wr(8'hA5);
      wr(8'hDE);
      wr(8'hAD);
      watch_quiet(150, "R7");

      // R12: lowering the selector below the count fires on the next edge
      wr(8'h04);
      wr(8'hA5);
      idle(100);
      wr(8'h02);
      check(rst_req == 1'b0, "R12 no request on selector edge", int'(rst_req), 0);
      @(negedge clk);
      check(rst_req == 1'b1, "R12 request after lowered selector", int'(rst_req), 1);
      @(negedge clk);
      check(rst_req == 1'b0, "R10 single-cycle request", int'(rst_req), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule